// File: doc/BRIEF.md
# Cascaded 16-Line Interrupt Controller Pair

This block joins two identical eight-channel interrupt controllers into one sixteen-line interrupt system. Device lines 0 to 7 feed the primary controller. Device lines 8 to 15 feed the secondary controller as its local lines 0 to 7. The secondary controller has a pending-request flag. That flag drives local input 2 of the primary, and that input passes through the primary's normal edge latch and priority logic like any other line. The CPU sees one request output, one acknowledge input and one 8-bit vector.

When the primary grants line 2 and the CPU acknowledges, the primary updates its own request and in-service state for line 2. The vector itself comes from the secondary controller's acknowledge. That acknowledge clears the secondary's pending flag, so the primary's line 2 falls, and the next secondary request makes a fresh rising edge. If a controller is acknowledged while its request register is empty, it returns its own base OR 7.

Each controller has a command window, a data window and an edge/level register, all reached through a simple byte write port with a combinational read port. Software must send an end-of-interrupt to each controller separately.

Top module: `cascade_irq_pair`

## Requirements
- R1: After reset, `int_req` and `vec_valid` are low. The data windows 0x21 and 0xA1 read 0xFF (all lines masked). The command window 0x20 reads 0x00 (request register). The edge/level registers at 0x4D0 and 0x4D1 read 0x00.
- R2: `dev_irq[7:0]` are primary lines 0 to 7, and `dev_irq[15:8]` are secondary lines 0 to 7. Primary line 2 is driven only by the secondary's pending request, so `dev_irq[2]` must be held low.
- R3: A rising edge on a line sets its request bit, and a falling edge clears it. On acknowledge, the granted bit is cleared when its edge/level bit is 0 (edge mode) and kept when it is 1 (level mode). A level-mode line that is still high requests again after its end-of-interrupt.
- R4: The request taken is the lowest-numbered pending line that is not masked. It is held back while an in-service bit of equal or lower number is set. With special mask mode on, in-service bits of masked lines are ignored in that comparison. A taken request stays asserted until it is acknowledged.
- R5: `int_ack` while `int_req` is high gives `vec_valid` for one cycle on the next cycle, with `vec` = base OR line number, and `int_req` low in that same cycle. `int_ack` while `int_req` is low is ignored: `vec_valid` stays low.
- R6: When the primary grants line 2, the vector is the secondary base OR the secondary line. The primary's line-2 request bit ends up clear. A later secondary request raises `int_req` again through a new edge.
- R7: An acknowledged controller whose request register is empty returns its base OR 7. In the secondary this also drops the primary's line 2, leaving no request.
- R8: A command-window write with bit 4 set starts initialization. It clears the request and in-service registers, masks all lines, turns automatic end-of-interrupt on and drops any pending request. Then come data writes in order: the base, a cascade word that is ignored, and, only if bit 0 of the first word was set, a mode word whose bit 1 selects automatic end-of-interrupt. Later data writes load the mask (1 = masked).
- R9: With automatic end-of-interrupt off, an acknowledge sets the in-service bit. Command writes with bits 4 and 3 both 0 are end-of-interrupt commands selected by bits 7:5. 001 clears the lowest-numbered in-service bit. 011 clears the bit named by bits 2:0. 110 and 111 change nothing. Any other code acts as 001.
- R10: A command write with bit 4 = 0 and bit 3 = 1 is a mode command. If bit 1 is set, bit 0 selects which register the command window reads: 1 for in-service, 0 for request. If bit 6 is set, bit 5 becomes the special-mask-mode flag. The data window reads the mask. The edge/level registers are written and read at 0x4D0 (primary) and 0x4D1 (secondary).
- R11: An end-of-interrupt sent to the secondary does not clear the primary's line-2 in-service bit. While that bit is set, a new secondary request is held back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_irq | input | 16 | Device interrupt lines; bit 2 reserved low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 16 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| int_req | output | 1 | Interrupt request to the CPU |
| int_ack | input | 1 | One-cycle acknowledge from the CPU |
| vec_valid | output | 1 | Vector is valid this cycle |
| vec | output | 8 | Interrupt vector |

## Verification
The assertions take for granted that `dev_irq[2]` is never driven high. That bit is the cascade position, and the block ignores it. They also take for granted that no register write is made in a cycle where the hold of a taken request is being checked. The stimulus ties line 2 low throughout. Every acknowledge and every line change is driven on the falling edge, so the acknowledge-to-vector relation is always seen against a settled request.

// File: rtl/cascade_irq_pair.sv
module cascade_irq_pair #(
  parameter logic [15:0] M_PORT = 16'h0020,
  parameter logic [15:0] S_PORT = 16'h00A0,
  parameter logic [15:0] M_TRIG = 16'h04D0,
  parameter logic [15:0] S_TRIG = 16'h04D1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] dev_irq,
  input  logic        wr_en,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        int_req,
  input  logic        int_ack,
  output logic        vec_valid,
  output logic [7:0]  vec
);
  localparam int CAS = 2;

  logic [7:0] lines [2];
  logic [1:0] req_v, spur_w, rd_hit, ack;
  logic [2:0] req_n [2];
  logic [7:0] vec_w [2];
  logic [7:0] rd_dat [2];

  function automatic logic [3:0] first_set(input logic [7:0] v);
    logic [3:0] r;
    r = 4'd0;
    for (int i = 7; i >= 0; i--) if (v[i]) r = {1'b1, 3'(i)};
    return r;
  endfunction

  assign lines[0] = {dev_irq[7:3], req_v[1], dev_irq[1:0]};
  assign lines[1] = dev_irq[15:8];
  assign ack[0]   = int_ack & req_v[0];
  assign ack[1]   = ack[0] & (req_n[0] == 3'(CAS)) & ~spur_w[0];
  assign int_req  = req_v[0];

  for (genvar c = 0; c < 2; c++) begin : g_ctl
    localparam logic [15:0] PA = (c == 0) ? M_PORT : S_PORT;
    localparam logic [15:0] PB = PA + 16'd1;
    localparam logic [15:0] PE = (c == 0) ? M_TRIG : S_TRIG;

    logic [7:0] irr_q, isr_q, msk_q, base_q, elcr_q, prev_q;
    logic [2:0] num_q;
    logic [1:0] step_q;
    logic       req_q, aeoi_q, rdisr_q, smm_q, want4_q;
    logic       wa, wb, we, spur, ocw2;
    logic [7:0] rise, fall, ack_bit, irr_clr, isr_set, isr_clr, irr_nx, isr_nx;
    logic [3:0] want, blk;
    logic       pick_ok;

    assign wa   = wr_en && addr == PA;
    assign wb   = wr_en && addr == PB;
    assign we   = wr_en && addr == PE;
    assign rise = lines[c] & ~prev_q;
    assign fall = ~lines[c] & prev_q;
    assign spur = !req_q || irr_q == 8'd0;

    assign want    = first_set(irr_q & ~msk_q);
    assign blk     = first_set(smm_q ? (isr_q & ~msk_q) : isr_q);
    assign pick_ok = want[3] && !(blk[3] && blk[2:0] <= want[2:0]);

    assign ack_bit = 8'd1 << num_q;
    assign irr_clr = (ack[c] && !spur) ? (ack_bit & ~elcr_q) : 8'd0;
    assign isr_set = (ack[c] && !spur && !aeoi_q) ? ack_bit : 8'd0;
    assign ocw2    = wa && !wdata[4] && !wdata[3];

    always_comb begin
      isr_clr = 8'd0;
      if (ocw2) begin
        if (wdata[7:5] == 3'b011)     isr_clr = 8'd1 << wdata[2:0];
        else if (wdata[7:6] != 2'b11) isr_clr = isr_q & (~isr_q + 8'd1);
      end
    end

    assign irr_nx = (irr_q | rise) & ~fall & ~irr_clr;
    assign isr_nx = (isr_q | isr_set) & ~isr_clr;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        irr_q <= '0; isr_q <= '0; msk_q <= 8'hFF; base_q <= '0; elcr_q <= '0;
        prev_q <= '0; num_q <= '0; step_q <= '0; req_q <= 1'b0; aeoi_q <= 1'b1;
        rdisr_q <= 1'b0; smm_q <= 1'b0; want4_q <= 1'b0;
      end else if (wa && wdata[4]) begin
        irr_q <= '0; isr_q <= '0; msk_q <= 8'hFF; prev_q <= '0;
        req_q <= 1'b0; aeoi_q <= 1'b1; want4_q <= wdata[0]; step_q <= 2'd1;
      end else begin
        prev_q <= lines[c];
        irr_q  <= irr_nx;
        isr_q  <= isr_nx;
        if (ack[c]) req_q <= 1'b0;
        else if (!req_q && pick_ok) begin
          req_q <= 1'b1;
          num_q <= want[2:0];
        end
        if (wa && wdata[3]) begin
          if (wdata[1]) rdisr_q <= wdata[0];
          if (wdata[6]) smm_q <= wdata[5];
        end
        if (wb) begin
          case (step_q)
            2'd0: if (want4_q) begin
                    aeoi_q  <= wdata[1];
                    want4_q <= 1'b0;
                  end else msk_q <= wdata;
            2'd1: begin base_q <= wdata; step_q <= 2'd2; end
            default: step_q <= 2'd0;
          endcase
        end
        if (we) elcr_q <= wdata;
      end
    end

    assign req_v[c]  = req_q;
    assign req_n[c]  = num_q;
    assign spur_w[c] = spur;
    assign vec_w[c]  = base_q | (spur ? 8'd7 : {5'd0, num_q});
    assign rd_hit[c] = addr == PA || addr == PB || addr == PE;
    assign rd_dat[c] = (addr == PA) ? (rdisr_q ? isr_q : irr_q) :
                       (addr == PB) ? msk_q : elcr_q;
  end

  assign rdata = rd_hit[0] ? rd_dat[0] : rd_hit[1] ? rd_dat[1] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec       <= 8'h00;
    end else begin
      vec_valid <= ack[0];
      if (ack[0]) vec <= ack[1] ? vec_w[1] : vec_w[0];
    end
  end
endmodule

module cascade_irq_pair_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] dev_irq,
  input logic        wr_en,
  input logic        int_req,
  input logic        int_ack,
  input logic        vec_valid
);
  p_cascade_pin_r2: assert property (@(posedge clk) disable iff (!rst_n) !dev_irq[2]);
  p_ack_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack && int_req |=> vec_valid);
  p_idle_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack && !int_req |=> !vec_valid);
  p_req_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack && int_req |=> !int_req);
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int_req && !int_ack && !wr_en |=> int_req);
endmodule

bind cascade_irq_pair cascade_irq_pair_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .wr_en(wr_en),
  .int_req(int_req), .int_ack(int_ack), .vec_valid(vec_valid)
);

// File: tb/tb_cascade_irq_pair.sv
module tb_cascade_irq_pair;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, int_ack = 1'b0;
  logic [15:0] dev_irq = '0, addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, vec;
  logic        int_req, vec_valid;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  cascade_irq_pair dut (
    .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .int_req(int_req), .int_ack(int_ack),
    .vec_valid(vec_valid), .vec(vec)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic req_is(input logic exp, input string tag);
    chk(tag, {7'd0, int_req}, {7'd0, exp});
  endtask

  task automatic ack_chk(input logic [7:0] exp, input string tag);
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
    chk({tag, " valid"}, {7'd0, vec_valid}, 8'd1);
    chk({tag, " vector"}, vec, exp);
    req_is(1'b0, {tag, " req drop"});
  endtask

  task automatic t_reset;
    req_is(1'b0, "R1 int_req");
    chk("R1 vec_valid", {7'd0, vec_valid}, 8'd0);
    rd(16'h0021, 8'hFF, "R1 master mask");
    rd(16'h00A1, 8'hFF, "R1 slave mask");
    rd(16'h0020, 8'h00, "R1 master irr");
    rd(16'h04D0, 8'h00, "R1 elcr");
  endtask

  task automatic t_init;
    wr(16'h0020, 8'h11); wr(16'h0021, 8'h08); wr(16'h0021, 8'h04); wr(16'h0021, 8'h01);
    wr(16'h00A0, 8'h11); wr(16'h00A1, 8'h70); wr(16'h00A1, 8'h02); wr(16'h00A1, 8'h01);
    wr(16'h0021, 8'h00); wr(16'h00A1, 8'h00);
  endtask

  task automatic t_basic;
    dev_irq[3] = 1'b1; tick(6);
    req_is(1'b1, "R2 line3 request");
    wr(16'h0020, 8'h0A);
    rd(16'h0020, 8'h08, "R3 irr edge latched");
    ack_chk(8'h0B, "R5 line3");
    wr(16'h0020, 8'h0B);
    rd(16'h0020, 8'h08, "R9 isr set on ack");
    wr(16'h0020, 8'h0A);
    rd(16'h0020, 8'h00, "R3 edge irr cleared on ack");
  endtask

  task automatic t_priority;
    dev_irq[5] = 1'b1; tick(6);
    req_is(1'b0, "R4 line5 blocked by isr3");
    dev_irq[1] = 1'b1; tick(6);
    req_is(1'b1, "R4 line1 preempts");
    ack_chk(8'h09, "R4 line1");
    wr(16'h0020, 8'h0B);
    rd(16'h0020, 8'h0A, "R9 isr 1 and 3");
    wr(16'h0020, 8'h20);
    rd(16'h0020, 8'h08, "R9 nonspecific eoi");
    tick(6);
    req_is(1'b0, "R4 still blocked");
    wr(16'h0020, 8'h63);
    tick(6);
    req_is(1'b1, "R9 specific eoi releases");
    ack_chk(8'h0D, "R4 line5");
    wr(16'h0020, 8'hC0);
    rd(16'h0020, 8'h20, "R9 code 110 no effect");
    wr(16'h0020, 8'h20);
    rd(16'h0020, 8'h00, "R9 isr empty");
    dev_irq[1] = 1'b0; dev_irq[3] = 1'b0; dev_irq[5] = 1'b0;
    tick(3);
    wr(16'h0020, 8'h0A);
  endtask

  task automatic t_idle_ack;
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
    chk("R5 ack ignored", {7'd0, vec_valid}, 8'd0);
  endtask

  task automatic t_cascade;
    dev_irq[12] = 1'b1; tick(6);
    req_is(1'b1, "R6 slave request reaches cpu");
    rd(16'h0020, 8'h04, "R6 master line2 latched");
    ack_chk(8'h74, "R6 slave vector");
    tick(3);
    rd(16'h0020, 8'h00, "R6 master line2 clear");
    wr(16'h0020, 8'h0B); wr(16'h00A0, 8'h0B);
    rd(16'h0020, 8'h04, "R6 master isr2");
    rd(16'h00A0, 8'h10, "R6 slave isr4");
    wr(16'h00A0, 8'h20);
    rd(16'h00A0, 8'h00, "R11 slave eoi");
    rd(16'h0020, 8'h04, "R11 master isr2 kept");
    dev_irq[9] = 1'b1; tick(6);
    req_is(1'b0, "R11 slave request held by isr2");
    wr(16'h0020, 8'h20); tick(6);
    req_is(1'b1, "R6 fresh cascade edge");
    ack_chk(8'h71, "R6 slave line1");
    wr(16'h00A0, 8'h20); wr(16'h0020, 8'h20);
    rd(16'h0020, 8'h00, "R9 master isr clean");
    rd(16'h00A0, 8'h00, "R9 slave isr clean");
    dev_irq[9] = 1'b0; dev_irq[12] = 1'b0;
    tick(3);
    wr(16'h0020, 8'h0A); wr(16'h00A0, 8'h0A);
  endtask

  task automatic t_mask;
    wr(16'h0021, 8'h02);
    dev_irq[1] = 1'b1; tick(6);
    req_is(1'b0, "R8 masked line");
    rd(16'h0021, 8'h02, "R10 mask readback");
    wr(16'h0021, 8'h00); tick(6);
    req_is(1'b1, "R8 unmask releases");
    ack_chk(8'h09, "R8 line1");
    wr(16'h0020, 8'h20);
    dev_irq[1] = 1'b0; tick(3);
  endtask

  task automatic t_level;
    wr(16'h04D0, 8'h01);
    rd(16'h04D0, 8'h01, "R10 master elcr");
    rd(16'h04D1, 8'h00, "R10 slave elcr");
    dev_irq[0] = 1'b1; tick(6);
    ack_chk(8'h08, "R3 level line0");
    rd(16'h0020, 8'h01, "R3 level irr kept");
    wr(16'h0020, 8'h20); tick(6);
    req_is(1'b1, "R3 level re-request");
    dev_irq[0] = 1'b0; tick(3);
    rd(16'h0020, 8'h00, "R3 fall clears irr");
    req_is(1'b1, "R4 request held");
    ack_chk(8'h0F, "R7 master spurious");
    tick(3);
    req_is(1'b0, "R7 idle after spurious");
    wr(16'h04D0, 8'h00);
  endtask

  task automatic t_slave_spur;
    dev_irq[14] = 1'b1; tick(6);
    req_is(1'b1, "R7 slave request");
    dev_irq[14] = 1'b0; tick(3);
    ack_chk(8'h77, "R7 slave spurious");
    tick(3);
    req_is(1'b0, "R7 cascade dropped");
    wr(16'h0020, 8'h0B);
    rd(16'h0020, 8'h04, "R7 master isr2");
    wr(16'h0020, 8'h20);
    wr(16'h0020, 8'h0A);
  endtask

  task automatic t_smm;
    dev_irq[1] = 1'b1; tick(6);
    ack_chk(8'h09, "R4 smm setup");
    dev_irq[4] = 1'b1; tick(6);
    req_is(1'b0, "R4 line4 blocked");
    wr(16'h0021, 8'h02); tick(6);
    req_is(1'b0, "R4 mask alone keeps block");
    wr(16'h0020, 8'h68); tick(6);
    req_is(1'b1, "R10 special mask on");
    ack_chk(8'h0C, "R4 line4 under smm");
    wr(16'h0020, 8'h48);
    wr(16'h0020, 8'h20); wr(16'h0020, 8'h20);
    wr(16'h0021, 8'h00);
    dev_irq[1] = 1'b0; dev_irq[4] = 1'b0; tick(3);
  endtask

  task automatic t_reinit;
    dev_irq[6] = 1'b1; tick(6);
    req_is(1'b1, "R8 pre-init request");
    wr(16'h0020, 8'h11);
    req_is(1'b0, "R8 init drops request");
    rd(16'h0021, 8'hFF, "R8 init masks all");
    wr(16'h0021, 8'h08); wr(16'h0021, 8'h04); wr(16'h0021, 8'h03);
    wr(16'h0021, 8'h00); tick(6);
    req_is(1'b1, "R8 request after init");
    ack_chk(8'h0E, "R8 line6");
    wr(16'h0020, 8'h0B);
    rd(16'h0020, 8'h00, "R8 auto eoi leaves isr empty");
    tick(6);
    req_is(1'b0, "R8 no further request");
    dev_irq[6] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_init();
    t_basic();
    t_priority();
    t_idle_ack();
    t_cascade();
    t_mask();
    t_level();
    t_slave_spur();
    t_smm();
    t_reinit();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule